// File: doc/BRIEF.md
# Two-level carry-lookahead adder

This block adds two 16-bit operands and a carry-in with no clock and no state. The operand width is split into four groups of four bits. Inside each group every bit position forms a generate term (both operand bits set) and a propagate term (the operand bits differ). All carries inside the group are then built at once as flat AND-OR expressions of those terms and the group's carry-in.

Each group also reports a group generate and a group propagate. A second lookahead stage applies the same flat equations to these four pairs and the block carry-in. It produces the carry into each upper group and the final carry-out, so no carry ripples from one group to the next.

The block exports its own propagate and generate pair. Four copies can therefore serve as the groups of a further lookahead stage that reaches 64 bits. Group width and group count are parameters. The defaults give the 16-bit, four-by-four arrangement.

Top module: `cla16`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i` for every input combination.
- R2: `cout_o` equals bit 16 of `a_i + b_i + cin_i`.
- R3: `blk_p_o` is 1 exactly when `a_i` and `b_i` differ in all 16 bit positions.
- R4: `blk_g_o` is 1 exactly when `a_i + b_i` (carry-in excluded) is at least 65536, so the block makes a carry-out on its own.
- R5: While `blk_p_o` is 1, `cout_o` equals `cin_i` and every bit of `sum_o` equals the inverse of `cin_i`.
- R6: `blk_p_o` and `blk_g_o` are never 1 together, and when both are 0 `cout_o` is 0.
- R7: `a_i` = 16'hFFFF, `b_i` = 0, `cin_i` = 1 gives `sum_o` = 0 and `cout_o` = 1, with the carry travelling through every bit position.
- R8: A carry that starts in one group reaches the groups above it correctly across the group boundaries between bits 3 and 4, bits 7 and 8, and bits 11 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| blk_p_o | output | 1 | Block propagate, for a further lookahead stage |
| blk_g_o | output | 1 | Block generate, for a further lookahead stage |

## Verification
Every output is purely combinational, so each result is due in the same clock cycle as the operands that produce it, with zero register stages. The bench applies a new operand set just after each rising edge. It compares all four outputs with its behavioural model at the following falling edge, after the logic has settled and well before the next set arrives. Directed vectors cover the full-length carry chain, carries that cross each group boundary, and the generate/propagate extremes. A long pseudo-random run covers the rest.

// File: rtl/cla16.sv
module cla16 #(
  parameter int GW = 4,
  parameter int NG = 4
) (
  input  logic [GW*NG-1:0] a_i,
  input  logic [GW*NG-1:0] b_i,
  input  logic             cin_i,
  output logic [GW*NG-1:0] sum_o,
  output logic             cout_o,
  output logic             blk_p_o,
  output logic             blk_g_o
);
  localparam int W  = GW * NG;
  localparam int LW = (GW > NG) ? GW : NG;

  function automatic logic [LW:0] look(input logic [LW-1:0] g, input logic [LW-1:0] p, input logic c0);
    logic [LW:0] c;
    logic t;
    c[0] = c0;
    for (int i = 0; i < LW; i++) begin
      c[i+1] = 1'b0;
      for (int j = 0; j <= i; j++) begin
        t = g[j];
        for (int k = j + 1; k <= i; k++) t = t & p[k];
        c[i+1] = c[i+1] | t;
      end
      t = c0;
      for (int k = 0; k <= i; k++) t = t & p[k];
      c[i+1] = c[i+1] | t;
    end
    return c;
  endfunction

  function automatic logic grp_gen(input logic [LW-1:0] g, input logic [LW-1:0] p, input int n);
    logic r;
    logic t;
    r = 1'b0;
    for (int j = 0; j < n; j++) begin
      t = g[j];
      for (int k = j + 1; k < n; k++) t = t & p[k];
      r = r | t;
    end
    return r;
  endfunction

  logic [W-1:0]  bit_g, bit_p;
  logic [NG-1:0] gp, gg;
  logic [NG:0]   gc;
  logic [LW:0]   top_c;

  assign bit_g = a_i & b_i;
  assign bit_p = a_i ^ b_i;

  for (genvar q = 0; q < NG; q++) begin : g_grp
    logic [LW-1:0] lg, lp;
    logic [LW:0]   lc;
    assign lg = LW'(bit_g[q*GW +: GW]);
    assign lp = LW'(bit_p[q*GW +: GW]);
    assign lc = look(lg, lp, gc[q]);
    assign gp[q] = &bit_p[q*GW +: GW];
    assign gg[q] = grp_gen(lg, lp, GW);
    assign sum_o[q*GW +: GW] = bit_p[q*GW +: GW] ^ lc[GW-1:0];
  end

  assign top_c   = look(LW'(gg), LW'(gp), cin_i);
  assign gc      = top_c[NG:0];
  assign cout_o  = gc[NG];
  assign blk_p_o = &gp;
  assign blk_g_o = grp_gen(LW'(gg), LW'(gp), NG);
endmodule

module cla16_chk #(
  parameter int GW = 4,
  parameter int NG = 4
) (
  input logic [GW*NG-1:0] a_i,
  input logic [GW*NG-1:0] b_i,
  input logic             cin_i,
  input logic [GW*NG-1:0] sum_o,
  input logic             cout_o,
  input logic             blk_p_o,
  input logic             blk_g_o
);
  localparam int W = GW * NG;
  logic [W:0] ref_full;
  logic [W:0] ref_gen;
  assign ref_full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign ref_gen  = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    // R1 R2
    sum_match_chk: assert ({cout_o, sum_o} == ref_full);
    // R3
    prop_match_chk: assert (blk_p_o == ((a_i ^ b_i) == {W{1'b1}}));
    // R4
    gen_match_chk: assert (blk_g_o == ref_gen[W]);
    // R5
    prop_pass_chk: assert (!blk_p_o || (cout_o == cin_i && sum_o == {W{~cin_i}}));
    // R6
    pg_excl_chk: assert (!(blk_p_o && blk_g_o));
    // R6
    kill_chk: assert (blk_p_o || blk_g_o || !cout_o);
  end
endmodule

bind cla16 cla16_chk #(.GW(GW), .NG(NG)) u_chk (.*);

// File: tb/sim_cla16.sv
module sim_cla16;
  logic clk = 1'b0;
  logic [15:0] a, b, sum;
  logic cin, cout, bp, bg;
  int checks = 0;
  int fails  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cla16 u0 (.a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout), .blk_p_o(bp), .blk_g_o(bg));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h", req, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c, input string tag);
    logic [16:0] full, gsum;
    @(posedge clk);
    #1;
    a = x; b = y; cin = c;
    full = {1'b0, x} + {1'b0, y} + {16'd0, c};
    gsum = {1'b0, x} + {1'b0, y};
    @(negedge clk);
    chk({"R1 ", tag}, {16'd0, sum}, {16'd0, full[15:0]});
    chk({"R2 ", tag}, {31'd0, cout}, {31'd0, full[16]});
    chk({"R3 ", tag}, {31'd0, bp}, {31'd0, ((x ^ y) == 16'hFFFF)});
    chk({"R4 ", tag}, {31'd0, bg}, {31'd0, gsum[16]});
  endtask

  initial begin
    logic [15:0] lfsr;
    a = '0; b = '0; cin = 1'b0;
    @(negedge clk);
    chk("R1 idle", {16'd0, sum}, 32'd0);
    chk("R2 idle", {31'd0, cout}, 32'd0);
    // R7 full-length carry chain
    apply(16'hFFFF, 16'h0000, 1'b1, "R7 chain");
    chk("R7 sum zero", {16'd0, sum}, 32'd0);
    chk("R7 carry out", {31'd0, cout}, 32'd1);
    apply(16'h0000, 16'hFFFF, 1'b1, "R7 swap");
    apply(16'hFFFE, 16'h0001, 1'b1, "R7 via bit0 gen");
    // R5 all-propagate with both carry-in values
    apply(16'hA5A5, 16'h5A5A, 1'b0, "R5 prop cin0");
    chk("R5 sum ones", {16'd0, sum}, 32'h0000FFFF);
    apply(16'hA5A5, 16'h5A5A, 1'b1, "R5 prop cin1");
    chk("R5 cout=cin", {31'd0, cout}, 32'd1);
    // R6 generate and kill extremes
    apply(16'hFFFF, 16'hFFFF, 1'b0, "R6 all gen");
    apply(16'h8000, 16'h8000, 1'b0, "R6 top gen");
    apply(16'h0000, 16'h0000, 1'b1, "R6 all kill");
    // R8 carries crossing each group boundary
    apply(16'h000F, 16'h0001, 1'b0, "R8 b3-4");
    apply(16'h00F0, 16'h0010, 1'b0, "R8 b7-8");
    apply(16'h0F00, 16'h0100, 1'b0, "R8 b11-12");
    apply(16'h0FFF, 16'h0000, 1'b1, "R8 three groups");
    apply(16'hF0F0, 16'h0F10, 1'b0, "R8 gen into prop");
    apply(16'h7FFF, 16'h0001, 1'b0, "R8 to sign");
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] x, y;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      x = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      y = (i % 4 == 0) ? ~x : lfsr;
      apply(x, y, lfsr[3], "R1 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule